// File: doc/BRIEF.md
# Standby Wake-Up Settling Controller

This system-control block holds one 8-bit control register and sequences the return from software standby. The register chooses how long the clock oscillator is given to settle, which edge of the non-maskable interrupt pin counts as a request, whether the condition-code UI flag behaves as a user flag or as an interrupt mask, and whether the on-chip RAM is enabled.

The CPU enters standby by pulsing `standby_enter`, and the block raises `halted`. A qualifying edge on the asynchronous `nmi_pin` is synchronised and detected. The block then loads a down-counter with a power-of-two number of clock states. The count is picked by a 3-bit code that was captured when standby was entered. When the count is used up, `resume` pulses for one cycle and `halted` drops. Wait codes that are not defined run the longest wait, so the CPU can never resume on an oscillator that has not settled. `BASE_LOG2` sets the shortest wait as 2^BASE_LOG2 states. It defaults to 13, which gives 8192 to 131072 states.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 8'h03 (wait code 0, falling edge, mask mode, reserved bit 1 set, RAM enabled). After reset `halted` and `resume` are 0, `ui_user_mode` is 0 and `ram_enable` is 1.
- R2: A write with `wr_en` stores bits [6:4] as the wait code, bit 3 as the UI mode, bit 2 as the NMI edge select and bit 0 as the RAM enable. `ui_user_mode` follows bit 3 and `ram_enable` follows bit 0.
- R3: Bit 1 always reads 1 and bit 7 always reads 0, whatever value is written to them.
- R4: A `standby_enter` pulse while the block is active sets `halted` on the next clock edge. `halted` stays set, and `resume` stays low, until a qualifying NMI edge has been seen.
- R5: Edge select 0 qualifies a falling edge of `nmi_pin` and edge select 1 a rising edge. The opposite edge neither raises `nmi_req` nor wakes the block. Each qualifying edge gives exactly one `nmi_req` pulse.
- R6: With wait code c in 0..4, the wait is N = 2^(BASE_LOG2+c) states. `resume` is high only during the cycle that follows the (N+2)-th rising clock edge after the pin changes; the pin is changed between clock edges. The extra two edges come from the two-stage synchroniser.
- R7: Wait codes 5, 6 and 7 give the longest wait, N = 2^(BASE_LOG2+4).
- R8: The wait length comes from the code held in the register when standby was entered. A write during standby changes the register but not the wait that is under way.
- R9: `resume` lasts exactly one cycle, and `halted` is 0 from the next clock edge on.
- R10: `ram_enable` changes only by a register write or by reset. Entering and leaving standby never change it.
- R11: If `standby_enter` arrives in the same cycle as a qualifying edge, the block goes straight into the settling wait. It uses the code in the register at that moment and resumes on the same cycle count as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| standby_enter | input | 1 | One-cycle request to enter software standby |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| nmi_req | output | 1 | One-cycle pulse per qualifying NMI edge |
| halted | output | 1 | CPU and peripherals held (standby or settling) |
| resume | output | 1 | One-cycle pulse releasing the CPU after settling |
| ui_user_mode | output | 1 | 1: UI flag is a user bit, 0: interrupt mask |
| ram_enable | output | 1 | On-chip RAM enable |

## Verification
Entry into standby and detection of the waking NMI edge can fall in the same cycle. This is the case that could leave the CPU asleep with its only wake-up event lost. The bench provokes it by changing the pin and then raising `standby_enter` exactly two clock edges later, which is the cycle in which the synchronised edge appears. It judges the result by requiring a single `resume` pulse at the R6 cycle count for the code in the register. A second overlap, a register write during an active wait, is judged by checking that the wait still runs the length of the code captured at entry.

// File: rtl/swc_pkg.sv
// Shared types and helpers for the standby wake-up settling controller.
// Assumes: a 3-bit wait code in which codes above 4 are undefined.
package swc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_SETTLE  = 2'd2
    } swc_state_e;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned MAX_STEP = 4;

    // Turns a raw wait code into a legal exponent step; undefined codes take the longest wait.
    function automatic logic [CODE_W-1:0] legal_step(input logic [CODE_W-1:0] code);
        return (code > CODE_W'(MAX_STEP)) ? CODE_W'(MAX_STEP) : code;
    endfunction

endpackage

// File: rtl/swc_ctrl_reg.sv
// Control register of the settling controller.
// Holds the wait code, UI mode, NMI edge select and RAM enable.
// Assumes: writes take effect at the clock edge; reads are combinational.
// Bit 1 is fixed at 1 and bit 7 at 0.
module swc_ctrl_reg
    import swc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [CODE_W-1:0] wait_code,
    output logic              user_mode,
    output logic              edge_rise,
    output logic              ram_en
);

    logic unused_reserved;
    assign unused_reserved = wr_data[7] ^ wr_data[1];

    // Stores the writable fields; the RAM enable is touched only by reset or a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_code <= '0;
            user_mode <= 1'b0;
            edge_rise <= 1'b0;
            ram_en    <= 1'b1;
        end else if (wr_en) begin
            wait_code <= wr_data[6:4];
            user_mode <= wr_data[3];
            edge_rise <= wr_data[2];
            ram_en    <= wr_data[0];
        end
    end

    // Packs the read value with its fixed reserved bits.
    always_comb begin
        rd_data = {1'b0, wait_code, user_mode, edge_rise, 1'b1, ram_en};
    end

    assert_ram_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ram_en));

endmodule

// File: rtl/swc_nmi_edge.sv
// NMI synchroniser and programmable edge detector.
// Assumes: the pin is asynchronous; STAGES >= 2.
// The flops reset to 0, and a change of edge select with a steady pin makes no edge.
module swc_nmi_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_rise,
    output logic hit
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    assign level = sync_q[STAGES-1];

    // Shifts the pin through the synchroniser and keeps the last synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= level;
        end
    end

    // Qualifies the level change against the selected edge.
    always_comb begin
        if (edge_rise) hit = level & ~prev_q;
        else           hit = ~level & prev_q;
    end

    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/swc_wait_timer.sv
// Settling down-counter. A start pulse loads (length - 1).
// done is high in the last counted cycle, after which the counter idles.
// Assumes: start is not raised while the counter is running.
module swc_wait_timer #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Loads on start, counts down while running, and stops after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Flags the final counted cycle.
    assign done = run_q && (cnt_q == '0);

    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start && cnt_q != '0) |=> (run_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

endmodule

// File: rtl/standby_wake_ctrl.sv
// Top of the standby wake-up settling controller.
// Sequences active -> standby -> settle -> active.
// The wait code is captured at standby entry, and a qualifying NMI edge starts
// a wait of 2^(BASE_LOG2+step) states.
// Assumes: standby_enter is a one-cycle request from the CPU.
// Other wake sources are handled elsewhere.
module standby_wake_ctrl
    import swc_pkg::*;
#(
    parameter int unsigned BASE_LOG2   = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       standby_enter,
    input  logic       nmi_pin,
    output logic       nmi_req,
    output logic       halted,
    output logic       resume,
    output logic       ui_user_mode,
    output logic       ram_enable
);

    localparam int unsigned CNT_W = BASE_LOG2 + MAX_STEP;

    swc_state_e        state_q;
    logic [CODE_W-1:0] reg_code;
    logic [CODE_W-1:0] held_code_q;
    logic [CODE_W-1:0] use_code;
    logic              edge_rise;
    logic              edge_hit;
    logic              timer_start;
    logic              timer_done;
    logic [CNT_W-1:0]  load_val;

    swc_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wait_code (reg_code),
        .user_mode (ui_user_mode),
        .edge_rise (edge_rise),
        .ram_en    (ram_enable)
    );

    swc_nmi_edge #(.STAGES(SYNC_STAGES)) u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (nmi_pin),
        .edge_rise (edge_rise),
        .hit       (edge_hit)
    );

    swc_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (timer_start),
        .load_val (load_val),
        .done     (timer_done)
    );

    // Chooses the code: live register on a coincident entry, otherwise the captured one.
    always_comb begin
        use_code = (state_q == ST_ACTIVE) ? reg_code : held_code_q;
        load_val = (CNT_W'(1) << (BASE_LOG2 + 32'(legal_step(use_code)))) - CNT_W'(1);
    end

    // Starts settling on a qualifying edge in standby, or together with the entry request.
    always_comb begin
        timer_start = edge_hit &&
                      ((state_q == ST_STANDBY) ||
                       (state_q == ST_ACTIVE && standby_enter));
    end

    // Steps the power-state machine and captures the wait code at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_ACTIVE;
            held_code_q <= '0;
        end else begin
            case (state_q)
                ST_ACTIVE: begin
                    if (standby_enter) begin
                        held_code_q <= reg_code;
                        state_q     <= edge_hit ? ST_SETTLE : ST_STANDBY;
                    end
                end
                ST_STANDBY: if (edge_hit)   state_q <= ST_SETTLE;
                ST_SETTLE:  if (timer_done) state_q <= ST_ACTIVE;
                default:                    state_q <= ST_ACTIVE;
            endcase
        end
    end

    // Drives the outputs seen by the CPU.
    always_comb begin
        halted  = (state_q != ST_ACTIVE);
        resume  = (state_q == ST_SETTLE) && timer_done;
        nmi_req = edge_hit;
    end

    assert_resume_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (!halted && !resume));

    assert_enter_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && standby_enter) |=> halted);

    assert_stay_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume) |=> halted);

    assert_active_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !standby_enter) |=> !halted);

endmodule

// File: tb/standby_wake_ctrl_tb.sv
module standby_wake_ctrl_tb;

    localparam int unsigned BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       standby_enter = 1'b0;
    logic       nmi_pin = 1'b1;
    logic       nmi_req, halted, resume, ui_user_mode, ram_enable;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    standby_wake_ctrl #(.BASE_LOG2(BASE), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .standby_enter(standby_enter), .nmi_pin(nmi_pin), .nmi_req(nmi_req),
        .halted(halted), .resume(resume), .ui_user_mode(ui_user_mode), .ram_enable(ram_enable)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wait_len(input int code);
        return (1 << BASE) << ((code > 4) ? 4 : code);
    endfunction

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic enter_standby();
        @(negedge clk); standby_enter = 1'b1;
        @(negedge clk); standby_enter = 1'b0;
    endtask

    // Changes the pin and measures the resume timing and the request pulses.
    task automatic wake_and_measure(input string req, input int exp_n, input bit expect_req);
        int first = 0;
        int pulses = 0;
        int reqs = 0;
        @(negedge clk); nmi_pin = ~nmi_pin;
        for (int i = 1; i <= exp_n + 8; i++) begin
            @(negedge clk);
            if (resume) begin
                pulses++;
                if (first == 0) first = i;
            end
            if (nmi_req) reqs++;
        end
        check({req, " resume cycle"}, first, exp_n + 2);
        check("R9 resume width", pulses, 1);
        check("R9 halted released", int'(halted), 0);
        if (expect_req) check("R5 nmi_req pulses", reqs, 1);
    endtask

    task automatic t_reset();
        check("R1 rd_data", int'(rd_data), 8'h03);
        check("R1 halted", int'(halted), 0);
        check("R1 resume", int'(resume), 0);
        check("R1 ui_user_mode", int'(ui_user_mode), 0);
        check("R1 ram_enable", int'(ram_enable), 1);
    endtask

    task automatic t_register();
        reg_write(8'hFF);
        check("R3 read after all ones", int'(rd_data), 8'h7F);
        check("R2 ui_user_mode set", int'(ui_user_mode), 1);
        reg_write(8'h00);
        check("R3 read after all zeros", int'(rd_data), 8'h02);
        check("R2 ram_enable cleared", int'(ram_enable), 0);
        check("R2 ui_user_mode cleared", int'(ui_user_mode), 0);
        reg_write(8'h25);
        check("R2 fields", int'(rd_data), 8'h27);
    endtask

    // Rising edge is selected; with the pin high, a falling edge must not wake.
    task automatic t_edge_select();
        int reqs = 0;
        reg_write(8'h05);
        enter_standby();
        check("R4 halted after entry", int'(halted), 1);
        @(negedge clk); nmi_pin = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (nmi_req || resume) reqs++;
        end
        check("R5 opposite edge ignored", reqs, 0);
        check("R4 still halted", int'(halted), 1);
        wake_and_measure("R6 rising code0", wait_len(0), 1'b1);
    endtask

    // Runs a wake for each code, choosing the edge that the current pin level can make.
    task automatic t_codes();
        int codes[7] = '{0, 1, 2, 3, 4, 5, 7};
        foreach (codes[k]) begin
            logic rise;
            rise = ~nmi_pin;
            reg_write({1'b0, 3'(codes[k]), 1'b0, rise, 1'b0, 1'b1});
            enter_standby();
            if (codes[k] > 4) wake_and_measure("R7 illegal code", wait_len(codes[k]), 1'b1);
            else              wake_and_measure("R6 legal code", wait_len(codes[k]), 1'b1);
        end
    endtask

    // A write during standby must not change the wait that is under way.
    task automatic t_latch();
        logic rise;
        rise = ~nmi_pin;
        reg_write({1'b0, 3'd1, 1'b0, rise, 1'b0, 1'b1});
        enter_standby();
        reg_write({1'b0, 3'd3, 1'b0, rise, 1'b0, 1'b1});
        check("R8 register updated in standby", int'(rd_data[6:4]), 3);
        wake_and_measure("R8 captured code", wait_len(1), 1'b0);
    endtask

    task automatic t_ram();
        logic rise;
        rise = ~nmi_pin;
        reg_write({1'b0, 3'd0, 1'b0, rise, 1'b0, 1'b0});
        enter_standby();
        check("R10 ram off in standby", int'(ram_enable), 0);
        wake_and_measure("R10 wake", wait_len(0), 1'b0);
        check("R10 ram off after wake", int'(ram_enable), 0);
        rise = ~nmi_pin;
        reg_write({1'b0, 3'd0, 1'b0, rise, 1'b0, 1'b1});
        enter_standby();
        wake_and_measure("R10 wake", wait_len(0), 1'b0);
        check("R10 ram on after wake", int'(ram_enable), 1);
    endtask

    // The entry request lands in the cycle in which the synchronised edge appears.
    task automatic t_coincident();
        logic rise;
        int first = 0;
        int pulses = 0;
        rise = ~nmi_pin;
        reg_write({1'b0, 3'd2, 1'b0, rise, 1'b0, 1'b1});
        @(negedge clk); nmi_pin = ~nmi_pin;
        for (int i = 1; i <= wait_len(2) + 8; i++) begin
            @(negedge clk);
            if (resume) begin
                pulses++;
                if (first == 0) first = i;
            end
            if (i == 2) begin
                check("R11 edge present at entry", int'(nmi_req), 1);
                standby_enter = 1'b1;
            end else begin
                standby_enter = 1'b0;
            end
            if (i == 4) check("R11 halted while settling", int'(halted), 1);
        end
        check("R11 resume cycle", first, wait_len(2) + 2);
        check("R11 single resume", pulses, 1);
        check("R11 released", int'(halted), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_register();
        t_edge_select();
        t_codes();
        t_latch();
        t_ram();
        t_coincident();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule